// File: doc/BRIEF.md
# Narrow-Port External Memory Sequencer

This block sits between a core that issues single 32-bit read and write requests and an external memory bus whose devices may be 8, 16 or 32 bits wide. Two memory areas are decoded from the request address: a boot PROM area split into two chip selects by address half, and a RAM area split into banks. Each area has its own port width and its own read and write wait-state counts. These settings come from static configuration inputs.

A request is split into as many bus sub-transfers as the area's port width needs: four for byte ports, two for halfword ports, one for word ports. The sub-transfers run at ascending addresses from the word-aligned base. Narrow devices sit on the most significant byte lanes of the data bus. The first sub-transfer carries the most significant part of the word. For reads, the block assembles the pieces into one word. It returns a single one-cycle completion pulse after the last sub-transfer. Between accesses the address bus keeps its last value. The data bus is driven only while a write strobe is active.

Top module: `narrow_bus_ctrl`

## Requirements
- R1: A request to a mapped area completes with `req_ready` high in the cycle that follows N*(W+1) bus cycles after the accepting clock edge. N is 4 for a byte port, 2 for a halfword port and 1 for a word port. W is the applicable wait-state count. Port width code: 0 = 8 bit, 1 = 16 bit, 2 or 3 = 32 bit.
- R2: Sub-transfer addresses start at the request address with bits 1:0 cleared. They rise by the port width in bytes (1, 2 or 4) from one sub-transfer to the next. `bus_addr` carries request address bits ADDR_W-1:0.
- R3: On writes, the first sub-transfer places the most significant byte (or halfword) of the write word on data lanes 31:24 (or 31:16). Later sub-transfers carry the following parts. Lanes that a narrow port does not use are driven to zero.
- R4: On reads, the first received byte or halfword becomes the most significant part of `resp_rdata`. A byte port reads only lanes 31:24 of `bus_rdata`, and a halfword port reads only lanes 31:16; the other lanes are ignored.
- R5: PROM area is addresses 0x00000000 to 0x1FFFFFFF. `prom_cs[0]` is asserted for 0x00000000 to 0x0FFFFFFF and `prom_cs[1]` for 0x10000000 to 0x1FFFFFFF. A select is asserted only while a read or write strobe is active.
- R6: RAM area is addresses 0x40000000 to 0x5FFFFFFF. The bank index is address bits 22:20. `ram_sel[index]` is asserted alone, and only while a strobe is active. An index of 5 or more is unmapped.
- R7: Each sub-transfer lasts W+1 cycles. W is taken from the area's read count for reads and from its write count for writes; the other count has no effect.
- R8: `bus_read` is asserted only during read sub-transfers and `bus_write` only during write sub-transfers, never both together. `bus_oe` is high only while `bus_write` is high, and `bus_wdata` is zero otherwise.
- R9: `bus_addr` is zero after reset. It keeps the address of the last sub-transfer while no strobe is active.
- R10: `req_ready` is a one-cycle pulse that never coincides with a strobe. An unmapped address completes in the cycle after acceptance with read data zero, and with no strobe and no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | DATA_W | Write word |
| req_ready | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Assembled read word, valid with `req_ready` |
| cfg_prom_pw | input | 2 | PROM port width code |
| cfg_ram_pw | input | 2 | RAM port width code |
| cfg_prom_rws | input | WS_W | PROM read wait states |
| cfg_prom_wws | input | WS_W | PROM write wait states |
| cfg_ram_rws | input | WS_W | RAM read wait states |
| cfg_ram_wws | input | WS_W | RAM write wait states |
| bus_addr | output | ADDR_W | External address bus |
| bus_wdata | output | DATA_W | Write data lanes |
| bus_oe | output | 1 | Data bus output enable |
| bus_rdata | input | DATA_W | Read data lanes |
| bus_read | output | 1 | Read strobe |
| bus_write | output | 1 | Write strobe |
| prom_cs | output | 2 | PROM chip selects, lower and upper half |
| ram_sel | output | NBANK | RAM bank selects |

## Verification
The bound checker watches every cycle for the properties that need no model of the data. It checks that the read and write strobes are exclusive, that selects are one-hot and appear only under a strobe, and that unused narrow lanes stay at zero. It also checks that the address holds while idle, that the address steps by the port width inside a transfer, and that the completion pulse lasts one cycle and is free of strobes. What only the bench scenarios can show is the data itself. That covers the byte ordering of assembled read words and of written pieces, the rejection of junk on unused read lanes, and the exact completion latency for each width and wait-state setting. It also covers the choice of read versus write wait count and the behaviour of unmapped addresses.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUS  = 2'd1,
      ST_DONE = 2'd2
   } seq_state_t;

   typedef enum logic [1:0] {
      RG_NONE = 2'd0,
      RG_PROM = 2'd1,
      RG_RAM  = 2'd2
   } region_t;

   localparam logic [1:0] PW_BYTE = 2'd0;
   localparam logic [1:0] PW_HALF = 2'd1;

   // bytes moved by one sub-transfer
   function automatic logic [2:0] beat_bytes(input logic [1:0] pw);
      case (pw)
         PW_BYTE: beat_bytes = 3'd1;
         PW_HALF: beat_bytes = 3'd2;
         default: beat_bytes = 3'd4;
      endcase
   endfunction

   // index of the final sub-transfer
   function automatic logic [1:0] final_beat(input logic [1:0] pw);
      case (pw)
         PW_BYTE: final_beat = 2'd3;
         PW_HALF: final_beat = 2'd1;
         default: final_beat = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/nbc_decode.sv
module nbc_decode
   import nbc_pkg::*;
#(
   parameter int NBANK    = 5,
   parameter int BANK_LSB = 20,
   parameter int AREA_W   = 3,
   parameter logic [AREA_W-1:0] PROM_TAG = '0,
   parameter logic [AREA_W-1:0] RAM_TAG  = 3'b010
) (
   input  logic [31:0]      addr,
   output region_t          region,
   output logic [1:0]       prom_sel,
   output logic [NBANK-1:0] bank_sel
);
   localparam int BANK_IW  = $clog2(NBANK);
   localparam int HALF_BIT = 31 - AREA_W;

   logic [AREA_W-1:0]  area;
   logic [BANK_IW-1:0] bidx;
   logic               bank_ok;
   logic [NBANK-1:0]   bank_hit;
   logic               unused_addr_bits;

   assign area             = addr[31 -: AREA_W];
   assign bidx             = addr[BANK_LSB +: BANK_IW];
   assign bank_ok          = (int'(bidx) < NBANK);
   assign unused_addr_bits = ^addr;

   always_comb begin
      region = RG_NONE;
      if (area == PROM_TAG)
         region = RG_PROM;
      else if (area == RAM_TAG && bank_ok)
         region = RG_RAM;
   end

   assign prom_sel = (region != RG_PROM) ? 2'b00 :
                     (addr[HALF_BIT] ? 2'b10 : 2'b01);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_hit[b] = (bidx == BANK_IW'(b));
      assign bank_sel[b] = (region == RG_RAM) && bank_hit[b];
   end

endmodule

// File: rtl/nbc_seq.sv
module nbc_seq
   import nbc_pkg::*;
#(
   parameter int ADDR_W = 28,
   parameter int WS_W   = 4,
   parameter int NBANK  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  region_t           region,
   input  logic [1:0]        prom_sel_in,
   input  logic [NBANK-1:0]  bank_sel_in,
   input  logic [1:0]        cfg_prom_pw,
   input  logic [1:0]        cfg_ram_pw,
   input  logic [WS_W-1:0]   cfg_prom_rws,
   input  logic [WS_W-1:0]   cfg_prom_wws,
   input  logic [WS_W-1:0]   cfg_ram_rws,
   input  logic [WS_W-1:0]   cfg_ram_wws,
   output logic              req_ready,
   output logic              bus_read,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        prom_cs,
   output logic [NBANK-1:0]  ram_sel,
   output logic [1:0]        beat_pw,
   output logic              start,
   output logic              beat_end
);
   seq_state_t        state;
   logic              wr_r;
   logic [1:0]        pw_r;
   logic [WS_W-1:0]   ws_r;
   logic [WS_W-1:0]   wcnt_r;
   logic [1:0]        beat_r;
   logic [ADDR_W-1:0] addr_r;
   logic [1:0]        prom_r;
   logic [NBANK-1:0]  ram_r;
   logic [1:0]        pw_in;
   logic [WS_W-1:0]   ws_in;
   logic              unused_lo;
   logic              in_bus;

   assign unused_lo = ^req_addr[1:0];

   always_comb begin
      if (region == RG_PROM) begin
         pw_in = cfg_prom_pw;
         ws_in = req_write ? cfg_prom_wws : cfg_prom_rws;
      end else begin
         pw_in = cfg_ram_pw;
         ws_in = req_write ? cfg_ram_wws : cfg_ram_rws;
      end
   end

   assign in_bus   = (state == ST_BUS);
   assign start    = (state == ST_IDLE) && req_valid;
   assign beat_end = in_bus && (wcnt_r == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         wr_r   <= 1'b0;
         pw_r   <= '0;
         ws_r   <= '0;
         wcnt_r <= '0;
         beat_r <= '0;
         addr_r <= '0;
         prom_r <= '0;
         ram_r  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               wr_r <= req_write;
               if (region == RG_NONE) begin
                  state <= ST_DONE;
               end else begin
                  state  <= ST_BUS;
                  pw_r   <= pw_in;
                  ws_r   <= ws_in;
                  wcnt_r <= ws_in;
                  beat_r <= '0;
                  addr_r <= {req_addr[ADDR_W-1:2], 2'b00};
                  prom_r <= prom_sel_in;
                  ram_r  <= bank_sel_in;
               end
            end
            ST_BUS: begin
               if (wcnt_r != '0) begin
                  wcnt_r <= wcnt_r - 1'b1;
               end else if (beat_r == final_beat(pw_r)) begin
                  state <= ST_DONE;
               end else begin
                  beat_r <= beat_r + 1'b1;
                  wcnt_r <= ws_r;
                  addr_r <= addr_r + ADDR_W'(beat_bytes(pw_r));
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_DONE);
   assign bus_read  = in_bus && !wr_r;
   assign bus_write = in_bus && wr_r;
   assign bus_addr  = addr_r;
   assign prom_cs   = in_bus ? prom_r : 2'b00;
   assign ram_sel   = in_bus ? ram_r : '0;
   assign beat_pw   = pw_r;

endmodule

// File: rtl/nbc_lanes.sv
module nbc_lanes
   import nbc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              beat_end,
   input  logic [1:0]        pw,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] rd_in,
   output logic [DATA_W-1:0] wr_lanes,
   output logic [DATA_W-1:0] asm_word
);
   localparam int NB = DATA_W / 8;

   logic [DATA_W-1:0] wsh;
   logic [2:0]        nbytes;

   assign nbytes = beat_bytes(pw);

   always_ff @(posedge clk) begin
      if (rst) begin
         wsh      <= '0;
         asm_word <= '0;
      end else if (start) begin
         wsh      <= wdata;
         asm_word <= '0;
      end else if (beat_end) begin
         case (pw)
            PW_BYTE: begin
               wsh      <= {wsh[DATA_W-9:0], 8'h00};
               asm_word <= {asm_word[DATA_W-9:0], rd_in[DATA_W-1 -: 8]};
            end
            PW_HALF: begin
               wsh      <= {wsh[DATA_W-17:0], 16'h0000};
               asm_word <= {asm_word[DATA_W-17:0], rd_in[DATA_W-1 -: 16]};
            end
            default: asm_word <= rd_in;
         endcase
      end
   end

   // lane i counted from the bottom; narrow ports occupy the top lanes
   for (genvar i = 0; i < NB; i++) begin : g_lane
      logic used;
      assign used = (3'(NB - 1 - i) < nbytes);
      assign wr_lanes[8*i +: 8] = used ? wsh[8*i +: 8] : 8'h00;
   end

endmodule

// File: rtl/narrow_bus_ctrl.sv
module narrow_bus_ctrl
   import nbc_pkg::*;
#(
   parameter int ADDR_W   = 28,
   parameter int DATA_W   = 32,
   parameter int NBANK    = 5,
   parameter int BANK_LSB = 20,
   parameter int WS_W     = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [31:0]       req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] resp_rdata,
   input  logic [1:0]        cfg_prom_pw,
   input  logic [1:0]        cfg_ram_pw,
   input  logic [WS_W-1:0]   cfg_prom_rws,
   input  logic [WS_W-1:0]   cfg_prom_wws,
   input  logic [WS_W-1:0]   cfg_ram_rws,
   input  logic [WS_W-1:0]   cfg_ram_wws,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_read,
   output logic              bus_write,
   output logic [1:0]        prom_cs,
   output logic [NBANK-1:0]  ram_sel
);
   localparam int BANK_IW = $clog2(NBANK);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("narrow_bus_ctrl: DATA_W must be 32");
   end
   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr_w
      $error("narrow_bus_ctrl: ADDR_W out of range");
   end
   if (NBANK < 2 || BANK_LSB + BANK_IW > 29) begin : g_bad_bank
      $error("narrow_bus_ctrl: bank field does not fit the RAM area");
   end
   if (WS_W < 1) begin : g_bad_ws
      $error("narrow_bus_ctrl: WS_W must be positive");
   end

   region_t          region;
   logic [1:0]       prom_sel;
   logic [NBANK-1:0] bank_sel;
   logic [1:0]       beat_pw;
   logic             start;
   logic             beat_end;
   logic [DATA_W-1:0] wr_lanes;

   nbc_decode #(
      .NBANK   (NBANK),
      .BANK_LSB(BANK_LSB)
   ) u_decode (
      .addr    (req_addr),
      .region  (region),
      .prom_sel(prom_sel),
      .bank_sel(bank_sel)
   );

   nbc_seq #(
      .ADDR_W(ADDR_W),
      .WS_W  (WS_W),
      .NBANK (NBANK)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr[ADDR_W-1:0]),
      .region      (region),
      .prom_sel_in (prom_sel),
      .bank_sel_in (bank_sel),
      .cfg_prom_pw (cfg_prom_pw),
      .cfg_ram_pw  (cfg_ram_pw),
      .cfg_prom_rws(cfg_prom_rws),
      .cfg_prom_wws(cfg_prom_wws),
      .cfg_ram_rws (cfg_ram_rws),
      .cfg_ram_wws (cfg_ram_wws),
      .req_ready   (req_ready),
      .bus_read    (bus_read),
      .bus_write   (bus_write),
      .bus_addr    (bus_addr),
      .prom_cs     (prom_cs),
      .ram_sel     (ram_sel),
      .beat_pw     (beat_pw),
      .start       (start),
      .beat_end    (beat_end)
   );

   nbc_lanes #(
      .DATA_W(DATA_W)
   ) u_lanes (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .beat_end(beat_end),
      .pw      (beat_pw),
      .wdata   (req_wdata),
      .rd_in   (bus_rdata),
      .wr_lanes(wr_lanes),
      .asm_word(resp_rdata)
   );

   assign bus_oe    = bus_write;
   assign bus_wdata = bus_oe ? wr_lanes : '0;

endmodule

// File: rtl/narrow_bus_ctrl_chk.sv
module narrow_bus_ctrl_chk #(
   parameter int ADDR_W = 28,
   parameter int DATA_W = 32,
   parameter int NBANK  = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic              bus_read,
   input logic              bus_write,
   input logic              bus_oe,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [1:0]        prom_cs,
   input logic [NBANK-1:0]  ram_sel,
   input logic [1:0]        beat_pw
);
   logic       strobe;
   logic [2:0] step;
   logic       unused_top;

   assign strobe     = bus_read || bus_write;
   assign unused_top = ^bus_wdata[DATA_W-1 -: 8];
   assign step       = (beat_pw == 2'd0) ? 3'd1 : (beat_pw == 2'd1) ? 3'd2 : 3'd4;

   // R8
   rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(bus_read && bus_write));

   // R8
   oe_dir_chk: assert property (@(posedge clk) disable iff (rst)
      bus_read |-> !bus_oe && bus_wdata == '0);

   // R5
   prom_sel_chk: assert property (@(posedge clk) disable iff (rst)
      (prom_cs != 2'b00) |-> strobe && $onehot0(prom_cs) && ram_sel == '0);

   // R6
   ram_sel_chk: assert property (@(posedge clk) disable iff (rst)
      (ram_sel != '0) |-> strobe && $onehot0(ram_sel));

   // R3
   byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_write && beat_pw == 2'd0) |-> bus_wdata[DATA_W-9:0] == '0);

   // R3
   half_lane_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_write && beat_pw == 2'd1) |-> bus_wdata[DATA_W-17:0] == '0);

   // R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !strobe |-> $stable(bus_addr));

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe && $past(strobe) && bus_addr != $past(bus_addr))
         |-> bus_addr == $past(bus_addr) + ADDR_W'(step));

   // R10
   ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      req_ready |=> !req_ready);

   // R10
   ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> !strobe);

endmodule

bind narrow_bus_ctrl narrow_bus_ctrl_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .NBANK (NBANK)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .req_ready(req_ready),
   .bus_read (bus_read),
   .bus_write(bus_write),
   .bus_oe   (bus_oe),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .prom_cs  (prom_cs),
   .ram_sel  (ram_sel),
   .beat_pw  (beat_pw)
);

// File: tb/narrow_bus_ctrl_test.sv
module narrow_bus_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 28;
   localparam int NBANK  = 5;

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] data;
      logic [1:0]  pw;
      logic [3:0]  ws;
   } vec_t;

   localparam vec_t VECS [0:7] = '{
      '{1'b0, 32'h0000_0100, 32'h0000_0000, 2'd0, 4'd0},
      '{1'b0, 32'h1000_2003, 32'h0000_0000, 2'd1, 4'd1},
      '{1'b0, 32'h4020_0040, 32'h0000_0000, 2'd2, 4'd2},
      '{1'b1, 32'h4000_0010, 32'h1234_5678, 2'd0, 4'd1},
      '{1'b1, 32'h1000_0020, 32'hCAFE_F00D, 2'd1, 4'd0},
      '{1'b1, 32'h4040_0008, 32'h8421_0FED, 2'd2, 4'd0},
      '{1'b0, 32'h4010_0006, 32'h0000_0000, 2'd0, 4'd3},
      '{1'b1, 32'h0000_0204, 32'hA1B2_C3D4, 2'd3, 4'd2}
   };

   logic              clk = 1'b0;
   logic              rst;
   logic              req_valid, req_write;
   logic [31:0]       req_addr, req_wdata;
   logic              req_ready;
   logic [31:0]       resp_rdata;
   logic [1:0]        cfg_prom_pw, cfg_ram_pw;
   logic [3:0]        cfg_prom_rws, cfg_prom_wws, cfg_ram_rws, cfg_ram_wws;
   logic [ADDR_W-1:0] bus_addr;
   logic [31:0]       bus_wdata, bus_rdata;
   logic              bus_oe, bus_read, bus_write;
   logic [1:0]        prom_cs;
   logic [NBANK-1:0]  ram_sel;
   logic [1:0]        cur_pw;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   narrow_bus_ctrl uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .resp_rdata(resp_rdata), .cfg_prom_pw(cfg_prom_pw), .cfg_ram_pw(cfg_ram_pw),
      .cfg_prom_rws(cfg_prom_rws), .cfg_prom_wws(cfg_prom_wws),
      .cfg_ram_rws(cfg_ram_rws), .cfg_ram_wws(cfg_ram_wws),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_oe(bus_oe),
      .bus_rdata(bus_rdata), .bus_read(bus_read), .bus_write(bus_write),
      .prom_cs(prom_cs), .ram_sel(ram_sel)
   );

   function automatic logic [7:0] mbyte(input logic [ADDR_W-1:0] a);
      return (a[7:0] * 8'd29) ^ 8'h5A;
   endfunction

   // memory model: narrow ports on top lanes, junk below
   always_comb begin
      case (cur_pw)
         2'd0:    bus_rdata = {mbyte(bus_addr), 24'hA5C3E1};
         2'd1:    bus_rdata = {mbyte(bus_addr), mbyte(bus_addr + 1), 16'h3CF0};
         default: bus_rdata = {mbyte(bus_addr), mbyte(bus_addr + 1),
                               mbyte(bus_addr + 2), mbyte(bus_addr + 3)};
      endcase
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic run_xfer(input logic wr, input logic [31:0] a, input logic [31:0] d,
                           input logic [1:0] pw, input int ws);
      logic [1:0]        exp_prom;
      logic [NBANK-1:0]  exp_ram;
      logic [2:0]        bank;
      logic [ADDR_W-1:0] base, prev;
      logic [7:0]        wmem [4];
      logic [31:0]       exp_rd;
      bit                mapped;
      int nbeats, nbytes, cyc, beats, scyc, sel_bad, addr_bad, lane_bad, dir_bad;
      bank     = a[22:20];
      exp_prom = (a[31:29] == 3'b000) ? (a[28] ? 2'b10 : 2'b01) : 2'b00;
      exp_ram  = (a[31:29] == 3'b010 && bank < 3'd5) ? NBANK'(1 << bank) : '0;
      mapped   = (exp_prom != 0) || (exp_ram != 0);
      nbytes   = (pw == 2'd0) ? 1 : (pw == 2'd1) ? 2 : 4;
      nbeats   = mapped ? 4 / nbytes : 0;
      base     = {a[ADDR_W-1:2], 2'b00};
      exp_rd   = {mbyte(base), mbyte(base + 1), mbyte(base + 2), mbyte(base + 3)};
      for (int k = 0; k < 4; k++) wmem[k] = 8'h00;
      cyc = 0; beats = 0; scyc = 0; sel_bad = 0; addr_bad = 0; lane_bad = 0; dir_bad = 0;
      prev = '0;
      @(negedge clk);
      cur_pw       = pw;
      cfg_prom_pw  = pw;
      cfg_ram_pw   = pw;
      cfg_prom_rws = wr ? 4'(ws + 3) : 4'(ws);
      cfg_ram_rws  = wr ? 4'(ws + 3) : 4'(ws);
      cfg_prom_wws = wr ? 4'(ws) : 4'(ws + 3);
      cfg_ram_wws  = wr ? 4'(ws) : 4'(ws + 3);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (cyc < 200) begin
         @(negedge clk);
         cyc++;
         if (req_ready) break;
         if (bus_read || bus_write) begin
            if (scyc == 0 || bus_addr != prev) begin
               if (bus_addr != base + ADDR_W'(beats * nbytes)) addr_bad++;
               beats++;
            end
            prev = bus_addr;
            scyc++;
            if (prom_cs != exp_prom || ram_sel != exp_ram) sel_bad++;
            if (bus_write != wr || bus_read == wr || bus_oe != wr) dir_bad++;
            if (wr) begin
               for (int k = 0; k < nbytes; k++)
                  wmem[2'(bus_addr[1:0] + k)] = bus_wdata[31 - 8*k -: 8];
               for (int k = nbytes; k < 4; k++)
                  if (bus_wdata[31 - 8*k -: 8] != 8'h00) lane_bad++;
            end
         end else if (bus_oe || bus_wdata != 0 || prom_cs != 0 || ram_sel != 0) begin
            dir_bad++;
         end
      end
      req_valid = 1'b0;
      if (mapped) begin
         chk(cyc == nbeats * (ws + 1) + 1, "R1", "completion latency", cyc, nbeats * (ws + 1) + 1);
         chk(beats == nbeats, "R1", "sub-transfer count", beats, nbeats);
         chk(addr_bad == 0, "R2", "sub-transfer addresses", addr_bad, 0);
         chk(scyc == nbeats * (ws + 1), "R7", "strobe cycles", scyc, nbeats * (ws + 1));
         chk(sel_bad == 0, (exp_prom != 0) ? "R5" : "R6", "chip select", sel_bad, 0);
         chk(dir_bad == 0, "R8", "strobe direction", dir_bad, 0);
         if (wr) begin
            chk({wmem[0], wmem[1], wmem[2], wmem[3]} == d, "R3", "written bytes",
                {wmem[0], wmem[1], wmem[2], wmem[3]}, d);
            chk(lane_bad == 0, "R3", "unused lanes zero", lane_bad, 0);
         end else begin
            chk(resp_rdata == exp_rd, "R4", "assembled read word", resp_rdata, exp_rd);
         end
      end else begin
         chk(cyc == 1, "R10", "unmapped latency", cyc, 1);
         chk(scyc == 0 && dir_bad == 0, "R10", "unmapped strobes", scyc, 0);
         if (!wr) chk(resp_rdata == 0, "R10", "unmapped read data", resp_rdata, 0);
      end
      @(negedge clk);
      chk(!req_ready, "R10", "ready pulse width", req_ready, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      cfg_prom_pw = '0; cfg_ram_pw = '0; cur_pw = '0;
      cfg_prom_rws = '0; cfg_prom_wws = '0; cfg_ram_rws = '0; cfg_ram_wws = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(bus_addr == 0, "R9", "reset address", 32'(bus_addr), 0);
      chk(!req_ready && !bus_read && !bus_write && !bus_oe, "R10", "reset strobes",
          {req_ready, bus_read, bus_write, bus_oe}, 0);
      chk(prom_cs == 0 && ram_sel == 0, "R5", "reset selects", {prom_cs, ram_sel}, 0);
      rst = 1'b0;
      @(negedge clk);

      for (int i = 0; i < 8; i++)
         run_xfer(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].pw, int'(VECS[i].ws));

      // R9 address held after a byte-port read ends
      run_xfer(1'b0, 32'h4010_0004, 32'h0, 2'd0, 0);
      repeat (3) @(negedge clk);
      chk(bus_addr == 28'h010_0007 && !bus_read && !bus_write, "R9", "address held",
          32'(bus_addr), 32'h0010_0007);

      // R10 unmapped areas and out-of-range bank (R6)
      run_xfer(1'b0, 32'h8000_0000, 32'h0, 2'd2, 1);
      run_xfer(1'b0, 32'h4050_0000, 32'h0, 2'd0, 2);
      run_xfer(1'b1, 32'h6000_0000, 32'h5555_AAAA, 2'd1, 0);

      // R7 large read wait count on a halfword PROM port
      run_xfer(1'b0, 32'h0000_0008, 32'h0, 2'd1, 5);

      summary();
      $finish;
   end

endmodule